// File: doc/BRIEF.md
# Cipher Key Admission and Self-Test Controller

This block is the control state machine that sits in front of a storage encryption datapath. The host stages a two-half cipher key (two halves of `KEY_HALF_W` bits, 256 by default) through write-only staging registers. It then issues a load command. The controller compares the halves in one cycle and refuses the key if they are equal. Otherwise it moves the key to the active registers, clears the staging registers, and starts a known-answer check on the external cipher through a start/done/pass handshake. The key is declared loaded only when that check passes.

A power-up integrity result gates everything. Until it arrives the block is not ready. If it reports failure, the block stays dead until the next power-on reset and answers every command with an integrity-failure code. A failed known-answer check latches a fatal error state: cryptography is disabled and keys are zeroized. In that state a zeroize command still clears keys, but only a power-on reset (`rst_n`) leaves the state. A status word reports the loaded, test and indicator flags.

States: `ST_WAIT_INTEG` (after reset, waiting for the integrity result), `ST_IDLE` (ready for commands), `ST_KAT_BUSY` (waiting for the check's done), `ST_ERR_KAT` (latched check failure), `ST_ERR_INTEG` (integrity failure).

Transitions:
- `ST_WAIT_INTEG` goes to `ST_IDLE` when the integrity result passes, and to `ST_ERR_INTEG` when it fails.
- `ST_IDLE` goes to `ST_KAT_BUSY` on an accepted load or on a self-test command.
- `ST_KAT_BUSY` goes to `ST_IDLE` when done arrives with pass, and to `ST_ERR_KAT` when done arrives without pass.
- `ST_ERR_KAT` and `ST_ERR_INTEG` are left only by reset.

Top module: `keyctl_top`

## Requirements
- R1: A load command (`cmd_code`=0) whose two staged halves are equal is refused with response code 2. The active key and the key-loaded flag are unchanged, and no check is started.
- R2: No port returns staged key material. Staging registers are cleared in the cycle after any load command, so a second load without new writes sees equal (zero) halves and is refused with code 2.
- R3: An accepted load, and a self-test command (`cmd_code`=1) in `ST_IDLE`, each raise `kat_start` for exactly one cycle, in the cycle after the command. An accepted load moves staged half 0 to `key1_out` and staged half 1 to `key2_out` in that same cycle.
- R4: When done arrives without pass, the block enters `ST_ERR_KAT` and answers code 3. In this state `crypto_en` is 0, status bit 8 (test failed) is 1, status bit 1 is 0 and both key outputs are zero. Later commands answer code 5 (locked) and start nothing. The exception is zeroize (`cmd_code`=2), which answers 0 and leaves the block locked. Only `rst_n` clears the state.
- R5: If the integrity result fails, every command answers code 4, key writes are ignored, no check is started, and status bits 2 and 7 stay 0.
- R6: Zeroize in `ST_IDLE` clears both key outputs and the key-loaded flag, and answers code 0.
- R7: The status word has these bits. Bit 0: key loaded. Bit 1: last check passed. Bit 2: integrity passed. Bit 3: last completed service was a key load. Bit 4: last completed service was a zeroize. Bit 5: last completed service was show-status (`cmd_code`=3). Bit 6: the `ENC_VERSION` parameter. Bit 7: approved mode (integrity passed and no check failure). Bit 8: check failed. At most one of bits 3 to 5 is set at a time.
- R8: `crypto_en` is 1 only in `ST_IDLE` with a key loaded. A key can only be loaded after both the integrity check and a known-answer check have passed.
- R9: The controller waits in `ST_KAT_BUSY` until `kat_done` is 1 and samples `kat_pass` in that cycle. The response appears one cycle later.
- R10: The key-loaded flag rises in the cycle after a passing done for a load. A passing self-test command keeps the current key loaded.
- R11: A command in `ST_WAIT_INTEG`, or in `ST_KAT_BUSY` in a cycle without `kat_done`, answers code 1 (busy) in the next cycle and changes no state or key.
- R12: After reset the block is in `ST_WAIT_INTEG`, both key outputs are zero, `crypto_en` and `cmd_resp_valid` are 0, and the status word holds only the version bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; the only exit from error states |
| integ_done | input | 1 | Power-up integrity result is valid |
| integ_pass | input | 1 | Integrity result: 1 passed |
| key_wr_en | input | 1 | Write one staging half |
| key_wr_sel | input | 1 | Half select: 0 first half, 1 second half |
| key_wr_data | input | KEY_HALF_W | Staging write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 load, 1 self-test, 2 zeroize, 3 show status |
| cmd_resp_valid | output | 1 | Response strobe |
| cmd_resp_code | output | 3 | 0 ok, 1 busy, 2 equal halves, 3 check failed, 4 integrity failed, 5 locked |
| kat_start | output | 1 | One-cycle start pulse to the cipher check |
| kat_done | input | 1 | Cipher check finished |
| kat_pass | input | 1 | Cipher check result, sampled with done |
| key1_out | output | KEY_HALF_W | Active first key half to the datapath |
| key2_out | output | KEY_HALF_W | Active second key half to the datapath |
| crypto_en | output | 1 | Encrypt/decrypt enable |
| status_word | output | 9 | Status flags (R7) |

## Verification
The bench builds the block with `KEY_HALF_W` = 4 and the default `ENC_VERSION` of 1. With 4-bit halves, every one of the 256 pairs of halves can be staged and loaded. That covers all 16 equal pairs that must be refused and every distinct pair, whose active key and status the bench predicts. It also checks a busy rejection during each check. Directed sequences then cover the self-test command, zeroize, a failing check with its lock-out, and the integrity-failure path after a fresh reset.

// File: rtl/keyctl_pkg.sv
package keyctl_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_INTEG = 3'd0,
        ST_IDLE       = 3'd1,
        ST_KAT_BUSY   = 3'd2,
        ST_ERR_KAT    = 3'd3,
        ST_ERR_INTEG  = 3'd4
    } ctl_state_t;

    typedef enum logic [1:0] {
        CMD_LOAD = 2'd0,
        CMD_TEST = 2'd1,
        CMD_ZERO = 2'd2,
        CMD_SHOW = 2'd3
    } ctl_cmd_t;

    typedef enum logic [2:0] {
        RSP_OK         = 3'd0,
        RSP_BUSY       = 3'd1,
        RSP_DUP        = 3'd2,
        RSP_KAT_FAIL   = 3'd3,
        RSP_INTEG_FAIL = 3'd4,
        RSP_LOCKED     = 3'd5
    } ctl_rsp_t;

    localparam int STATUS_W   = 9;
    localparam int SB_LOADED  = 0;
    localparam int SB_KAT_OK  = 1;
    localparam int SB_INTEG   = 2;
    localparam int SB_IND_LO  = 3;
    localparam int SB_VERSION = 6;
    localparam int SB_APPROVE = 7;
    localparam int SB_KAT_ERR = 8;

endpackage

// File: rtl/keyctl_key_store.sv
module keyctl_key_store #(
    parameter int HALF_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              commit,
    input  logic              clear_stage,
    input  logic              zeroize,
    output logic              halves_equal,
    output logic [HALF_W-1:0] key1_q,
    output logic [HALF_W-1:0] key2_q
);
    localparam int NUM_HALVES = 2;
    localparam int FLAT_W     = NUM_HALVES * HALF_W;

    logic [FLAT_W-1:0] stage_flat;
    logic [FLAT_W-1:0] act_flat;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic [HALF_W-1:0] stg_q;
        logic [HALF_W-1:0] act_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q <= '0;
            end else if (commit || clear_stage || zeroize) begin
                stg_q <= '0;
            end else if (wr_en && (wr_sel == h[0])) begin
                stg_q <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (zeroize) begin
                act_q <= '0;
            end else if (commit) begin
                act_q <= stg_q;
            end
        end

        assign stage_flat[h*HALF_W +: HALF_W] = stg_q;
        assign act_flat[h*HALF_W +: HALF_W]   = act_q;
    end

    assign halves_equal = (stage_flat[HALF_W-1:0] == stage_flat[FLAT_W-1:HALF_W]);
    assign key1_q       = act_flat[HALF_W-1:0];
    assign key2_q       = act_flat[FLAT_W-1:HALF_W];

    AST_NO_DUP_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !halves_equal); // R1

    AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit || clear_stage) |=> (stage_flat == '0)); // R2

    AST_ZEROIZE_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> (act_flat == '0)); // R6

endmodule

// File: rtl/keyctl_fsm.sv
module keyctl_fsm
    import keyctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       integ_done,
    input  logic       integ_pass,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       halves_equal,
    input  logic       kat_done,
    input  logic       kat_pass,
    output logic       commit,
    output logic       clear_stage,
    output logic       zeroize,
    output logic       wr_allow,
    output logic       kat_start,
    output logic       busy,
    output logic       idle,
    output logic       resp_valid,
    output logic [2:0] resp_code,
    output logic       key_loaded,
    output logic       kat_ok,
    output logic       kat_fail,
    output logic       integ_ok,
    output logic [2:0] ind
);
    ctl_state_t state_q, state_d;
    ctl_cmd_t   cmd;
    ctl_rsp_t   rsp_d;
    logic       rsp_v_d;
    logic       start_d;
    logic       is_load_q, is_load_d;
    logic       ev_integ_ok, ev_load_go, ev_kat_pass, ev_kat_fail, ev_zero, ev_show;

    assign cmd = ctl_cmd_t'(cmd_code);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_WAIT_INTEG;
            is_load_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            is_load_q <= is_load_d;
        end
    end

    // Next state and control events
    always_comb begin
        state_d     = state_q;
        is_load_d   = is_load_q;
        commit      = 1'b0;
        clear_stage = 1'b0;
        zeroize     = 1'b0;
        start_d     = 1'b0;
        rsp_v_d     = 1'b0;
        rsp_d       = RSP_OK;
        ev_integ_ok = 1'b0;
        ev_load_go  = 1'b0;
        ev_kat_pass = 1'b0;
        ev_kat_fail = 1'b0;
        ev_zero     = 1'b0;
        ev_show     = 1'b0;
        unique case (state_q)
            ST_WAIT_INTEG: begin
                if (cmd_valid) begin
                    rsp_v_d = 1'b1;
                    rsp_d   = RSP_BUSY;
                end
                if (integ_done) begin
                    if (integ_pass) begin
                        state_d     = ST_IDLE;
                        ev_integ_ok = 1'b1;
                    end else begin
                        state_d = ST_ERR_INTEG;
                    end
                end
            end
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd)
                        CMD_LOAD: begin
                            if (halves_equal) begin
                                clear_stage = 1'b1;
                                rsp_v_d     = 1'b1;
                                rsp_d       = RSP_DUP;
                            end else begin
                                commit     = 1'b1;
                                start_d    = 1'b1;
                                is_load_d  = 1'b1;
                                ev_load_go = 1'b1;
                                state_d    = ST_KAT_BUSY;
                            end
                        end
                        CMD_TEST: begin
                            start_d   = 1'b1;
                            is_load_d = 1'b0;
                            state_d   = ST_KAT_BUSY;
                        end
                        CMD_ZERO: begin
                            zeroize = 1'b1;
                            ev_zero = 1'b1;
                            rsp_v_d = 1'b1;
                            rsp_d   = RSP_OK;
                        end
                        CMD_SHOW: begin
                            ev_show = 1'b1;
                            rsp_v_d = 1'b1;
                            rsp_d   = RSP_OK;
                        end
                        default: ;
                    endcase
                end
            end
            ST_KAT_BUSY: begin
                if (kat_done) begin
                    rsp_v_d = 1'b1;
                    if (kat_pass) begin
                        ev_kat_pass = 1'b1;
                        rsp_d       = RSP_OK;
                        state_d     = ST_IDLE;
                    end else begin
                        ev_kat_fail = 1'b1;
                        zeroize     = 1'b1;
                        rsp_d       = RSP_KAT_FAIL;
                        state_d     = ST_ERR_KAT;
                    end
                end else if (cmd_valid) begin
                    rsp_v_d = 1'b1;
                    rsp_d   = RSP_BUSY;
                end
            end
            ST_ERR_KAT: begin
                if (cmd_valid) begin
                    rsp_v_d = 1'b1;
                    if (cmd == CMD_ZERO) begin
                        zeroize = 1'b1;
                        ev_zero = 1'b1;
                        rsp_d   = RSP_OK;
                    end else begin
                        rsp_d = RSP_LOCKED;
                    end
                end
            end
            ST_ERR_INTEG: begin
                if (cmd_valid) begin
                    rsp_v_d = 1'b1;
                    rsp_d   = RSP_INTEG_FAIL;
                end
            end
            default: state_d = ST_ERR_INTEG;
        endcase
    end

    // Registered outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kat_start  <= 1'b0;
            resp_valid <= 1'b0;
            resp_code  <= RSP_OK;
            key_loaded <= 1'b0;
            kat_ok     <= 1'b0;
            kat_fail   <= 1'b0;
            integ_ok   <= 1'b0;
            ind        <= 3'b000;
        end else begin
            kat_start  <= start_d;
            resp_valid <= rsp_v_d;
            resp_code  <= rsp_d;
            if (ev_integ_ok) integ_ok <= 1'b1;
            if (ev_load_go) key_loaded <= 1'b0;
            if (ev_kat_pass) begin
                kat_ok <= 1'b1;
                if (is_load_q) begin
                    key_loaded <= 1'b1;
                    ind        <= 3'b001;
                end
            end
            if (ev_kat_fail) begin
                kat_ok     <= 1'b0;
                kat_fail   <= 1'b1;
                key_loaded <= 1'b0;
                ind        <= 3'b000;
            end
            if (ev_zero) begin
                key_loaded <= 1'b0;
                ind        <= 3'b010;
            end
            if (ev_show) ind <= 3'b100;
        end
    end

    assign wr_allow = (state_q == ST_IDLE);
    assign busy     = (state_q == ST_KAT_BUSY);
    assign idle     = (state_q == ST_IDLE);

    AST_ERR_KAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_KAT) |=> (state_q == ST_ERR_KAT)); // R4

    AST_ERR_INTEG_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_INTEG) |=> ((state_q == ST_ERR_INTEG) && !kat_start)); // R5

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> !kat_start); // R3

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        kat_start |=> !kat_start); // R3

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_KAT_BUSY) && !kat_done) |=> (state_q == ST_KAT_BUSY)); // R9

endmodule

// File: rtl/keyctl_status.sv
module keyctl_status
    import keyctl_pkg::*;
#(
    parameter bit ENC_VERSION = 1'b1
) (
    input  logic                key_loaded,
    input  logic                kat_ok,
    input  logic                kat_fail,
    input  logic                integ_ok,
    input  logic [2:0]          ind,
    output logic [STATUS_W-1:0] word
);
    always_comb begin
        word                    = '0;
        word[SB_LOADED]         = key_loaded;
        word[SB_KAT_OK]         = kat_ok;
        word[SB_INTEG]          = integ_ok;
        word[SB_IND_LO +: 3]    = ind;
        word[SB_VERSION]        = ENC_VERSION;
        word[SB_APPROVE]        = integ_ok && !kat_fail;
        word[SB_KAT_ERR]        = kat_fail;
    end
endmodule

// File: rtl/keyctl_top.sv
module keyctl_top
    import keyctl_pkg::*;
#(
    parameter int KEY_HALF_W  = 256,
    parameter bit ENC_VERSION = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  integ_done,
    input  logic                  integ_pass,
    input  logic                  key_wr_en,
    input  logic                  key_wr_sel,
    input  logic [KEY_HALF_W-1:0] key_wr_data,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_code,
    output logic                  cmd_resp_valid,
    output logic [2:0]            cmd_resp_code,
    output logic                  kat_start,
    input  logic                  kat_done,
    input  logic                  kat_pass,
    output logic [KEY_HALF_W-1:0] key1_out,
    output logic [KEY_HALF_W-1:0] key2_out,
    output logic                  crypto_en,
    output logic [8:0]            status_word
);
    logic       commit, clear_stage, zeroize, wr_allow, busy, idle, halves_equal;
    logic       key_loaded, kat_ok, kat_fail, integ_ok;
    logic [2:0] ind;

    keyctl_key_store #(.HALF_W(KEY_HALF_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (key_wr_en && wr_allow),
        .wr_sel       (key_wr_sel),
        .wr_data      (key_wr_data),
        .commit       (commit),
        .clear_stage  (clear_stage),
        .zeroize      (zeroize),
        .halves_equal (halves_equal),
        .key1_q       (key1_out),
        .key2_q       (key2_out)
    );

    keyctl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .integ_done   (integ_done),
        .integ_pass   (integ_pass),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .halves_equal (halves_equal),
        .kat_done     (kat_done),
        .kat_pass     (kat_pass),
        .commit       (commit),
        .clear_stage  (clear_stage),
        .zeroize      (zeroize),
        .wr_allow     (wr_allow),
        .kat_start    (kat_start),
        .busy         (busy),
        .idle         (idle),
        .resp_valid   (cmd_resp_valid),
        .resp_code    (cmd_resp_code),
        .key_loaded   (key_loaded),
        .kat_ok       (kat_ok),
        .kat_fail     (kat_fail),
        .integ_ok     (integ_ok),
        .ind          (ind)
    );

    keyctl_status #(.ENC_VERSION(ENC_VERSION)) u_status (
        .key_loaded (key_loaded),
        .kat_ok     (kat_ok),
        .kat_fail   (kat_fail),
        .integ_ok   (integ_ok),
        .ind        (ind),
        .word       (status_word)
    );

    assign crypto_en = idle && key_loaded;

    AST_NO_CRYPTO_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        kat_fail |-> !crypto_en); // R4

    AST_CRYPTO_NEEDS_TESTS: assert property (@(posedge clk) disable iff (!rst_n)
        crypto_en |-> (integ_ok && kat_ok)); // R8

    AST_IND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ind)); // R7

    AST_LOADED_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_loaded) |-> $past(kat_done && kat_pass && busy)); // R10

    AST_KEYS_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !kat_done) |=> ($stable(key1_out) && $stable(key2_out))); // R11

endmodule

// File: tb/keyctl_top_test.sv
module keyctl_top_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         integ_done = 1'b0, integ_pass = 1'b0;
    logic         key_wr_en = 1'b0, key_wr_sel = 1'b0;
    logic [W-1:0] key_wr_data = '0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_code = 2'd0;
    logic         cmd_resp_valid;
    logic [2:0]   cmd_resp_code;
    logic         kat_start;
    logic         kat_done = 1'b0, kat_pass = 1'b0;
    logic [W-1:0] key1_out, key2_out;
    logic         crypto_en;
    logic [8:0]   status_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    keyctl_top #(.KEY_HALF_W(W), .ENC_VERSION(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .integ_done(integ_done), .integ_pass(integ_pass),
        .key_wr_en(key_wr_en), .key_wr_sel(key_wr_sel), .key_wr_data(key_wr_data),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_resp_valid(cmd_resp_valid),
        .cmd_resp_code(cmd_resp_code), .kat_start(kat_start), .kat_done(kat_done),
        .kat_pass(kat_pass), .key1_out(key1_out), .key2_out(key2_out),
        .crypto_en(crypto_en), .status_word(status_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [W-1:0] d);
        key_wr_en = 1'b1; key_wr_sel = sel; key_wr_data = d;
        tick();
        key_wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic done(input logic p);
        kat_done = 1'b1; kat_pass = p;
        tick();
        kat_done = 1'b0; kat_pass = 1'b0;
    endtask

    task automatic power_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog act=1 exp=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] e1, e2;
        logic         eload;
        power_reset();
        // R12 reset state
        chk("R12 status", status_word, 9'h040);
        chk("R12 crypto_en", crypto_en, 0);
        chk("R12 resp_valid", cmd_resp_valid, 0);
        chk("R12 keys", {key1_out, key2_out}, 0);
        // R11 command before integrity result
        cmd(2'd3);
        chk("R11 busy before integ", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd1});
        integ_done = 1'b1; integ_pass = 1'b1;
        tick();
        integ_done = 1'b0;
        chk("R7 integ bits", status_word, 9'h0C4);

        // R1 R3 R9 R10 R8 exhaustive sweep over all half pairs
        e1 = '0; e2 = '0; eload = 1'b0;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                wr(1'b0, W'(a));
                wr(1'b1, W'(b));
                cmd(2'd0);
                if (a == b) begin
                    chk("R1 dup resp", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd2});
                    chk("R1 no start", kat_start, 0);
                    chk("R1 key kept", {key1_out, key2_out}, {e1, e2});
                    chk("R1 loaded kept", status_word[0], eload);
                end else begin
                    chk("R3 start", kat_start, 1);
                    chk("R3 key moved", {key1_out, key2_out}, {W'(a), W'(b)});
                    chk("R8 no crypto busy", crypto_en, 0);
                    cmd(2'd3);
                    chk("R11 busy reject", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd1});
                    chk("R3 single pulse", kat_start, 0);
                    tick();
                    chk("R9 waiting", {cmd_resp_valid, status_word[0]}, 0);
                    done(1'b1);
                    chk("R9 resp ok", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd0});
                    chk("R10 status", status_word, 9'h0CF);
                    chk("R8 crypto_en", crypto_en, 1);
                    e1 = W'(a); e2 = W'(b); eload = 1'b1;
                end
            end
        end

        // R2 second load without writes sees cleared staging
        cmd(2'd0);
        chk("R2 staging cleared", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd2});
        chk("R2 key kept", {key1_out, key2_out}, {e1, e2});

        // R7 show indicator
        cmd(2'd3);
        chk("R7 show", status_word, 9'h0E7);

        // R10 manual self-test keeps key
        cmd(2'd1);
        chk("R3 manual start", kat_start, 1);
        done(1'b1);
        chk("R10 manual keeps key", {status_word[0], crypto_en, key1_out, key2_out},
            {1'b1, 1'b1, e1, e2});

        // R6 zeroize
        cmd(2'd2);
        chk("R6 resp", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd0});
        chk("R6 keys", {key1_out, key2_out}, 0);
        chk("R6 status", status_word, 9'h0D6);
        chk("R8 off after zero", crypto_en, 0);

        // R4 check failure
        wr(1'b0, 4'h3);
        wr(1'b1, 4'hC);
        cmd(2'd0);
        done(1'b0);
        chk("R4 resp", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd3});
        chk("R4 status", status_word, 9'h144);
        chk("R4 keys", {key1_out, key2_out}, 0);
        chk("R4 crypto_en", crypto_en, 0);
        wr(1'b0, 4'h1);
        wr(1'b1, 4'h2);
        cmd(2'd0);
        chk("R4 load locked", {cmd_resp_valid, cmd_resp_code, kat_start}, {1'b1, 3'd5, 1'b0});
        cmd(2'd1);
        chk("R4 test locked", {cmd_resp_valid, cmd_resp_code, kat_start}, {1'b1, 3'd5, 1'b0});
        cmd(2'd2);
        chk("R4 zero ok", {cmd_resp_valid, cmd_resp_code}, {1'b1, 3'd0});
        chk("R4 still locked", status_word[8], 1);
        cmd(2'd3);
        chk("R4 show locked", cmd_resp_code, 3'd5);

        // R12 power reset clears lock
        power_reset();
        chk("R12 after lock", status_word, 9'h040);

        // R5 integrity failure
        integ_done = 1'b1; integ_pass = 1'b0;
        tick();
        integ_done = 1'b0;
        wr(1'b0, 4'h5);
        wr(1'b1, 4'hA);
        for (int c = 0; c < 4; c++) begin
            cmd(2'(c));
            chk("R5 integ fail resp", {cmd_resp_valid, cmd_resp_code, kat_start},
                {1'b1, 3'd4, 1'b0});
        end
        chk("R5 keys untouched", {key1_out, key2_out}, 0);
        chk("R5 status", status_word, 9'h040);
        chk("R5 crypto_en", crypto_en, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule